// File: doc/BRIEF.md
# Six-bit carry-save array multiplier

A purely combinational unsigned 6x6 multiplier meant to sit inside a larger multiplier. Every partial-product bit is a plain AND of one bit of each operand, with no recoding. The block does not finish the product. It returns two words, `sum_lo` and `sum_hi`, whose weighted sum equals the product. The enclosing design adds them, or feeds them into a wider reduction tree.

Partial-product bit `mcand[i] & mplier[k]` belongs to column `i+k`. The rows for multiplicand bits 0 to 4 are reduced one column at a time. Each column goes through a counter that reports how many of its bits are set. The three bits of each count are weighted by the column, the column above it and the column two above, and the weighted counts are added into the 11-bit word `sum_lo`. The row for multiplicand bit 5 is not reduced. It leaves the block unchanged as the 6-bit word `sum_hi`, which stands for bit positions 10 down to 5. Positions 4 to 0 of that second word are zero by definition and have no pins. There is no clock and no state. Any pipeline register belongs to the enclosing design.

Top module: `csa_mul6`

## Requirements
- R1: For every pair of unsigned 6-bit operands, `sum_lo + sum_hi * 32` equals `mcand * mplier`, taken modulo 4096.
- R2: `sum_hi` holds the partial-product row of multiplicand bit 5: `sum_hi[k] = mcand[5] & mplier[k]` for k = 0..5, so that bit k has weight 2^(k+5).
- R3: `sum_lo` equals the exact product of the low five multiplicand bits and the multiplier, `mcand[4:0] * mplier`, which never exceeds 1953 and so never wraps 11 bits.
- R4: If either operand is zero, both output words are zero.
- R5: No column counter reports more set bits than the column holds. A column of rows 0..4 holds at most five bits.
- R6: The outputs depend only on the present operand values: repeating a pair gives the same words, whatever pairs came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 6 | Multiplicand, unsigned |
| mplier | input | 6 | Multiplier, unsigned |
| sum_lo | output | 11 | First carry-save word, bit positions 10..0 |
| sum_hi | output | 6 | Second carry-save word, bit positions 10..5 |

## Verification
The immediate checks inside the block evaluate only when both operands are known 0/1 values. They assume the operands are stable long enough for the combinational words to settle. The stimulus changes both operands together, once per period, away from the sampling point. It holds them steady until the bench has read the outputs. Every one of the 4096 operand pairs is applied, so the bound on column heights and the wrap-free low word are exercised at their extremes, including 63 x 63.

// File: rtl/csa_mul6.sv
module csa_mul6 #(
  parameter int W = 6
) (
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  output logic [2*W-2:0]   sum_lo,
  output logic [2*W-2:W-1] sum_hi
);

  localparam int ROWS = W - 1;
  localparam int NCOL = ROWS + W - 1;
  localparam int PW   = 2*W - 1;
  localparam int CW   = $clog2(ROWS + 1);

  logic [CW-1:0] col_cnt [NCOL];
  logic [PW-1:0] wt [CW];

  always_comb begin
    for (int j = 0; j < NCOL; j++) begin
      col_cnt[j] = '0;
      for (int i = 0; i < ROWS; i++) begin
        if (j - i >= 0 && j - i < W)
          col_cnt[j] = col_cnt[j] + CW'(mcand[i] & mplier[j-i]);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < CW; g++) begin : g_wt
      always_comb begin
        wt[g] = '0;
        for (int j = 0; j < NCOL; j++)
          if (j + g < PW) wt[g][j+g] = col_cnt[j][g];
      end
    end
  endgenerate

  always_comb begin
    sum_lo = '0;
    for (int k = 0; k < CW; k++)
      sum_lo = sum_lo + wt[k];
  end

  assign sum_hi = mplier & {W{mcand[W-1]}};

  logic [2*W-1:0] chk_prod, chk_total;
  assign chk_prod  = (2*W)'(mcand) * (2*W)'(mplier);
  assign chk_total = (2*W)'(sum_lo) + ((2*W)'(sum_hi) << (W-1));

  always_comb begin
    if (!$isunknown({mcand, mplier})) begin
      a_r1_words_sum_to_product: assert (chk_total == chk_prod);
      a_r2_high_word_is_top_row: assert (mcand[W-1] || sum_hi == '0);
      a_r3_low_word_bounded: assert (32'(sum_lo) <= ((1 << ROWS) - 1) * ((1 << W) - 1));
      a_r4_zero_operand: assert (!(mcand == '0 || mplier == '0) || (sum_lo == '0 && sum_hi == '0));
    end
  end

  generate
    for (g = 0; g < NCOL; g++) begin : g_cnt_chk
      always_comb begin
        if (!$isunknown({mcand, mplier}))
          a_r5_count_in_range: assert (32'(col_cnt[g]) <= ROWS);
      end
    end
  endgenerate

endmodule

// File: tb/csa_mul6_test.sv
module csa_mul6_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  mcand, mplier;
  logic [10:0] sum_lo;
  logic [5:0]  sum_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  csa_mul6 uut (
    .mcand(mcand),
    .mplier(mplier),
    .sum_lo(sum_lo),
    .sum_hi(sum_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d)", req, act, exp, mcand, mplier);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(posedge clk);
    mcand  = 6'(x);
    mplier = 6'(y);
    @(negedge clk);
  endtask

  function automatic int hi_row(input int x, input int y);
    return ((x >> 5) & 1) ? y : 0;
  endfunction

  task automatic check_pair(input int x, input int y);
    int total;
    apply(x, y);
    total = int'(sum_lo) + int'(sum_hi) * 32;
    check("R1", total % 4096, (x * y) % 4096);
    check("R2", int'(sum_hi), hi_row(x, y));
    check("R3", int'(sum_lo), (x % 32) * y);
  endtask

  initial begin
    mcand = '0;
    mplier = '0;
    @(negedge clk);
    check("R4", int'(sum_lo), 0);
    check("R4", int'(sum_hi), 0);

    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        check_pair(x, y);

    // R4: zero on either side with full-scale partner
    apply(0, 63);
    check("R4", int'(sum_lo) + int'(sum_hi), 0);
    apply(63, 0);
    check("R4", int'(sum_lo) + int'(sum_hi), 0);

    // R5: tallest columns full of ones, largest low word
    apply(31, 63);
    check("R5", int'(sum_lo), 1953);
    check("R5", int'(sum_hi), 0);

    // R6: same pair after different histories
    apply(63, 63);
    check("R6", int'(sum_lo) + int'(sum_hi) * 32, 3969);
    apply(0, 0);
    apply(63, 63);
    check("R6", int'(sum_lo), 1953);
    check("R6", int'(sum_hi), 63);
    apply(42, 21);
    apply(21, 42);
    check("R6", int'(sum_lo) + int'(sum_hi) * 32, 882);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule